// File: doc/BRIEF.md
# PLL Lock and Bandwidth-Mode Supervisor

This block is the digital supervisor of a phase-locked loop. It counts rising edges of the divided feedback clock over fixed windows of reference-clock periods, and it compares each window's count with the count a correctly tuned loop would produce. Only frequency is compared; phase plays no part. From the size of each window's error it selects the loop filter's bandwidth. Wide acquisition mode permits large corrections and is used at start-up and after a large frequency disturbance. Narrow tracking mode permits only small corrections once the loop is close to the target.

It also raises a lock flag when the feedback clock is fit to become the system clock source. Software polls this flag or waits for the lock interrupt before it switches the system clock. A manual mode lets software choose the bandwidth directly in place of the automatic selection.

Top module: `pll_lock_supervisor`

## Requirements
- R1: After reset the block is in acquisition (`mode_trk_stat` = 0, `filter_wide` = 1), with `lock_flag` = 0 and `lock_irq` = 0.
- R2: `mode_trk_stat` is 1 in tracking and 0 in acquisition. `filter_wide` is its inverse at all times, and any state that is not acquisition is tracking.
- R3: With `auto_bw_en` = 0, the mode follows `man_track_sel` (1 = tracking, 0 = acquisition) one reference clock after it is sampled, and the window results do not change it.
- R4: With `auto_bw_en` = 1 in acquisition, two consecutive windows whose count error is at most TRK_TOL (default 4) switch the block to tracking. A window outside that band restarts the run.
- R5: With `auto_bw_en` = 1 in tracking, a single window whose count error exceeds TRK_TOL returns the block to acquisition.
- R6: In tracking, `lock_flag` sets after LOCK_WINS (default 4) consecutive windows whose error is at most LOCK_TOL (default 1).
- R7: `lock_flag` clears on the first window whose error exceeds LOCK_TOL. It is 0 whenever the block is in acquisition.
- R8: Each change of `lock_flag` while `lock_irq_en` = 1 sets `lock_irq`. It stays set until a cycle with `lock_irq_ack` = 1 (write one to clear). A change while the enable is 0 leaves it clear.
- R9: A window is WIN_LEN (default 32) reference periods long. The expected count is EXP_CNT (default 8) feedback rising edges, and the error is the absolute difference between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all logic runs in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_clk | input | 1 | Divided feedback clock, asynchronous to ref_clk |
| auto_bw_en | input | 1 | 1 = automatic mode selection, 0 = manual |
| man_track_sel | input | 1 | Manual mode select: 1 = tracking, 0 = acquisition |
| lock_irq_en | input | 1 | Enables the lock-change interrupt |
| lock_irq_ack | input | 1 | Write-one-to-clear for the pending interrupt |
| filter_wide | output | 1 | To the loop filter: 1 = wide acquisition bandwidth |
| lock_flag | output | 1 | Loop locked; feedback clock usable as system clock |
| mode_trk_stat | output | 1 | Mode status: 1 = tracking, 0 = acquisition |
| lock_irq | output | 1 | Pending lock-change interrupt request |

## Verification
On every cycle the assertions check four things: that the filter select and the mode status are complementary, that the lock flag is never set in acquisition, that the manual select is obeyed when automatic mode is off, and that a pending interrupt survives until it is acknowledged. They also check that the lock flag only rises at a window boundary and that a window's edge count stays within its bound. Only the bench's scenarios can show the counted consequences of window errors. These are the two-window entry into tracking, the single-window fall back, the four-window lock qualification and the interrupt on each lock change. The bench drives a known number of feedback edges into each window and compares the outputs with a window-by-window model.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
   typedef enum logic {
      BW_ACQ = 1'b0,
      BW_TRK = 1'b1
   } bw_mode_e;

   function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
      return (a > b) ? (a - b) : (b - a);
   endfunction
endpackage

// File: rtl/fb_edge_sync.sv
module fb_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("fb_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q[s] <= 1'b0;
         end else if (s == 0) begin
            sync_q[s] <= async_in;
         end else begin
            sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise_pulse = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/freq_window.sv
module freq_window #(
   parameter int WIN_LEN = 32,
   localparam int TW = $clog2(WIN_LEN),
   localparam int CW = $clog2(WIN_LEN + 1) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_in,
   output logic          win_done,
   output logic [CW-1:0] win_count
);
   if (WIN_LEN < 4) begin : g_bad_win
      $error("freq_window: WIN_LEN must be at least 4");
   end

   logic [TW-1:0] tick_q;
   logic [CW-1:0] cnt_q;

   assign win_done  = (tick_q == TW'(WIN_LEN - 1));
   assign win_count = cnt_q + CW'(edge_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         cnt_q  <= '0;
      end else if (win_done) begin
         tick_q <= '0;
         cnt_q  <= '0;
      end else begin
         tick_q <= tick_q + 1'b1;
         cnt_q  <= cnt_q + CW'(edge_in);
      end
   end

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(WIN_LEN));
endmodule

// File: rtl/bw_lock_fsm.sv
module bw_lock_fsm
   import pll_lock_pkg::*;
#(
   parameter int CW        = 7,
   parameter int EXP_CNT   = 8,
   parameter int LOCK_TOL  = 1,
   parameter int TRK_TOL   = 4,
   parameter int TRK_WINS  = 2,
   parameter int LOCK_WINS = 4,
   localparam int TSW = $clog2(TRK_WINS + 1),
   localparam int LSW = $clog2(LOCK_WINS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          auto_en,
   input  logic          man_trk,
   input  logic          win_done,
   input  logic [CW-1:0] win_count,
   output bw_mode_e      mode,
   output logic          locked
);
   if (LOCK_TOL > TRK_TOL) begin : g_bad_tol
      $error("bw_lock_fsm: LOCK_TOL must not exceed TRK_TOL");
   end
   if (TRK_WINS < 1 || LOCK_WINS < 1) begin : g_bad_wins
      $error("bw_lock_fsm: window run lengths must be at least 1");
   end

   bw_mode_e       mode_q, mode_d;
   logic           lock_d;
   logic [TSW-1:0] trk_run_q, trk_run_d;
   logic [LSW-1:0] lock_run_q, lock_run_d;
   int unsigned    err;
   logic           in_trk_band, in_lock_band;

   assign err          = abs_diff(int'(win_count), EXP_CNT);
   assign in_trk_band  = (err <= TRK_TOL);
   assign in_lock_band = (err <= LOCK_TOL);

   always_comb begin
      mode_d    = mode_q;
      trk_run_d = trk_run_q;
      if (!auto_en) begin
         mode_d    = man_trk ? BW_TRK : BW_ACQ;
         trk_run_d = '0;
      end else if (win_done) begin
         if (mode_q == BW_ACQ) begin
            if (!in_trk_band) begin
               trk_run_d = '0;
            end else if (trk_run_q == TSW'(TRK_WINS - 1)) begin
               mode_d    = BW_TRK;
               trk_run_d = '0;
            end else begin
               trk_run_d = trk_run_q + 1'b1;
            end
         end else begin
            trk_run_d = '0;
            if (!in_trk_band) mode_d = BW_ACQ;
         end
      end
   end

   always_comb begin
      lock_d     = locked;
      lock_run_d = lock_run_q;
      if (mode_d == BW_ACQ || mode_q == BW_ACQ) begin
         lock_d     = 1'b0;
         lock_run_d = '0;
      end else if (win_done) begin
         if (!in_lock_band) begin
            lock_d     = 1'b0;
            lock_run_d = '0;
         end else if (lock_run_q == LSW'(LOCK_WINS - 1) || locked) begin
            lock_d     = 1'b1;
            lock_run_d = LSW'(LOCK_WINS - 1);
         end else begin
            lock_run_d = lock_run_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= BW_ACQ;
         locked     <= 1'b0;
         trk_run_q  <= '0;
         lock_run_q <= '0;
      end else begin
         mode_q     <= mode_d;
         locked     <= lock_d;
         trk_run_q  <= trk_run_d;
         lock_run_q <= lock_run_d;
      end
   end

   assign mode = mode_q;

   assert_lock_needs_trk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (mode == BW_TRK));
   assert_manual_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> (mode == ($past(man_trk) ? BW_TRK : BW_ACQ)));
   assert_lock_at_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !$past(locked)) |-> $past(win_done));
endmodule

// File: rtl/lock_irq_ctrl.sv
module lock_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_in,
   input  logic irq_en,
   input  logic irq_ack,
   output logic irq_req
);
   logic lock_prev_q;
   logic change;

   assign change = lock_in ^ lock_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_prev_q <= 1'b0;
         irq_req     <= 1'b0;
      end else begin
         lock_prev_q <= lock_in;
         if (change && irq_en) irq_req <= 1'b1;
         else if (irq_ack)     irq_req <= 1'b0;
      end
   end

   assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> irq_req);
endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
   import pll_lock_pkg::*;
#(
   parameter int WIN_LEN     = 32,
   parameter int EXP_CNT     = 8,
   parameter int LOCK_TOL    = 1,
   parameter int TRK_TOL     = 4,
   parameter int TRK_WINS    = 2,
   parameter int LOCK_WINS   = 4,
   parameter int SYNC_STAGES = 2,
   localparam int CW = $clog2(WIN_LEN + 1) + 1
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic fb_clk,
   input  logic auto_bw_en,
   input  logic man_track_sel,
   input  logic lock_irq_en,
   input  logic lock_irq_ack,
   output logic filter_wide,
   output logic lock_flag,
   output logic mode_trk_stat,
   output logic lock_irq
);
   if (EXP_CNT < 1 || 2 * EXP_CNT > WIN_LEN) begin : g_bad_exp
      $error("pll_lock_supervisor: EXP_CNT must lie in 1..WIN_LEN/2");
   end

   logic          fb_rise;
   logic          win_done;
   logic [CW-1:0] win_count;
   bw_mode_e      mode;

   fb_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(ref_clk), .rst_n(rst_n), .async_in(fb_clk), .rise_pulse(fb_rise));

   freq_window #(.WIN_LEN(WIN_LEN)) u_win (
      .clk(ref_clk), .rst_n(rst_n), .edge_in(fb_rise),
      .win_done(win_done), .win_count(win_count));

   bw_lock_fsm #(
      .CW(CW), .EXP_CNT(EXP_CNT), .LOCK_TOL(LOCK_TOL), .TRK_TOL(TRK_TOL),
      .TRK_WINS(TRK_WINS), .LOCK_WINS(LOCK_WINS)
   ) u_fsm (
      .clk(ref_clk), .rst_n(rst_n), .auto_en(auto_bw_en), .man_trk(man_track_sel),
      .win_done(win_done), .win_count(win_count), .mode(mode), .locked(lock_flag));

   lock_irq_ctrl u_irq (
      .clk(ref_clk), .rst_n(rst_n), .lock_in(lock_flag), .irq_en(lock_irq_en),
      .irq_ack(lock_irq_ack), .irq_req(lock_irq));

   assign mode_trk_stat = (mode == BW_TRK);
   assign filter_wide   = (mode == BW_ACQ);

   assert_filter_inv_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      filter_wide != mode_trk_stat);
endmodule

// File: tb/pll_lock_supervisor_tb_top.sv
`timescale 1ns/1ps
module pll_lock_supervisor_tb_top;
   localparam int WIN = 32;
   localparam int EXP = 8;

   logic ref_clk = 1'b0;
   logic rst_n = 1'b0;
   logic fb_clk = 1'b0;
   logic auto_bw_en = 1'b1, man_track_sel = 1'b0, lock_irq_en = 1'b0, lock_irq_ack = 1'b0;
   logic filter_wide, lock_flag, mode_trk_stat, lock_irq;

   int total = 0, bad = 0;
   bit done = 0;

   bit m_trk, m_lock, m_irq;
   int m_trun, m_lrun;

   always #4 ref_clk = ~ref_clk;

   pll_lock_supervisor dut_i (
      .ref_clk(ref_clk), .rst_n(rst_n), .fb_clk(fb_clk), .auto_bw_en(auto_bw_en),
      .man_track_sel(man_track_sel), .lock_irq_en(lock_irq_en), .lock_irq_ack(lock_irq_ack),
      .filter_wide(filter_wide), .lock_flag(lock_flag), .mode_trk_stat(mode_trk_stat),
      .lock_irq(lock_irq));

   function automatic int abs_err(input int c);
      return (c > EXP) ? c - EXP : EXP - c;
   endfunction

   task automatic check(input string tag, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic set_lock(input bit v);
      if (v != m_lock && lock_irq_en) m_irq = 1;
      m_lock = v;
   endtask

   // model of one window's decision
   task automatic model_window(input int c);
      int  e = abs_err(c);
      bit  old = m_trk;
      if (old) begin
         if (e <= 1) begin
            if (m_lrun < 4) m_lrun++;
            if (m_lrun >= 4) set_lock(1);
         end else begin
            m_lrun = 0;
            set_lock(0);
         end
      end else begin
         m_lrun = 0;
         set_lock(0);
      end
      if (auto_bw_en) begin
         if (!old) begin
            if (e <= 4) m_trun++; else m_trun = 0;
            if (m_trun == 2) begin m_trk = 1; m_trun = 0; end
         end else begin
            m_trun = 0;
            if (e > 4) begin m_trk = 0; m_lrun = 0; end
         end
      end
   endtask

   task automatic run_window(input int c, input bit a, input bit m, input bit en, input bit ack);
      for (int o = 0; o < WIN; o++) begin
         @(negedge ref_clk);
         if (o == 0) begin
            auto_bw_en = a; man_track_sel = m; lock_irq_en = en;
            if (!a) begin
               m_trun = 0;
               m_trk = m;
               if (!m_trk) begin m_lrun = 0; set_lock(0); end
            end
         end
         if (o == 1) begin
            lock_irq_ack = ack;
            if (ack) m_irq = 0;
         end
         if (o == 2) begin
            lock_irq_ack = 0;
            check("R2 mode_trk_stat", mode_trk_stat, m_trk);
            check("R2 filter_wide", filter_wide, !m_trk);
            check("R6/R7 lock_flag", lock_flag, m_lock);
            check("R8 lock_irq", lock_irq, m_irq);
         end
         fb_clk = (o >= 4 && o < 4 + 2*c && ((o - 4) % 2 == 0));
      end
      model_window(c);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      m_trk = 0; m_lock = 0; m_irq = 0; m_trun = 0; m_lrun = 0;
      repeat (3) @(negedge ref_clk);
      // R1: reset state
      check("R1 lock_flag", lock_flag, 0);
      check("R1 filter_wide", filter_wide, 1);
      check("R1 mode_trk_stat", mode_trk_stat, 0);
      check("R1 lock_irq", lock_irq, 0);
      rst_n = 1;
      // R9/R4: two in-band windows (error 3 then 4) enter tracking
      run_window(11, 1, 0, 1, 0);
      run_window(4, 1, 0, 1, 0);
      // R6: four exact windows qualify lock
      for (int i = 0; i < 4; i++) run_window(EXP, 1, 0, 1, 0);
      run_window(7, 1, 0, 1, 1);
      // R7: error 2 drops lock but stays tracking
      run_window(10, 1, 0, 1, 0);
      run_window(9, 1, 0, 1, 1);
      // R5: error 5 returns to acquisition
      run_window(3, 1, 0, 1, 0);
      // R4: broken run (in, out, in) does not switch
      run_window(8, 1, 0, 0, 1);
      run_window(0, 1, 0, 0, 0);
      run_window(8, 1, 0, 0, 0);
      run_window(8, 1, 0, 0, 0);
      // R3: manual tracking ignores a huge error, manual acquisition ignores exact counts
      run_window(12, 0, 1, 1, 0);
      run_window(0, 0, 1, 1, 0);
      for (int i = 0; i < 5; i++) run_window(EXP, 0, 1, 1, 0);
      run_window(EXP, 0, 0, 0, 1);
      run_window(EXP, 0, 0, 0, 0);
      run_window(EXP, 0, 0, 0, 0);
      // random mix
      for (int i = 0; i < 120; i++) begin
         int pick[9] = '{8, 7, 9, 6, 10, 3, 12, 0, 8};
         int c = pick[$urandom_range(8)];
         bit a = ($urandom_range(9) != 0);
         bit m = $urandom_range(1);
         bit en = ($urandom_range(3) != 0);
         bit ack = ($urandom_range(3) == 0);
         run_window(c, a, m, en, ack);
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_200_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule